// File: doc/BRIEF.md
# Precise exception tracker

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It keeps the exception record of each instruction and carries it down the pipeline with the instruction. The fetch, decode, execute and memory stages each report fault causes for the instruction they hold. The block ORs those causes into the instruction's own flag vector. It does nothing about them until the instruction reaches writeback.

While an instruction carries any flag, its data-memory store and its register-file write are blocked. The instruction still flows to writeback. When a flagged instruction is in writeback, the block raises a trap. The trap reports one cause code and the PC of the faulting instruction. In the same cycle it clears every younger slot and redirects fetch to a fixed handler address. Because a record is only acted on in writeback, faults are taken in program order, even when a younger instruction faults earlier in time.

An external interrupt request is attached to the instruction in writeback. That instruction completes normally. The trap then reports the interrupt cause and the address of the next sequential instruction.

Top module: `exc_tracker`

## Requirements
- R1: While reset is held, and after it with no fetch, no slot is occupied: `trap_o`, `trap_cause_o`, `trap_pc_o`, `next_pc_o`, `mem_we_o` and `rf_we_o` are all 0.
- R2: An instruction accepted with `if_valid_i` advances one slot per clock and sits in writeback exactly four cycles later. If it carries no flags and no trap is taken, `rf_we_o` follows `rf_we_req_i` during that writeback cycle.
- R3: Causes are posted only for the instruction occupying the reporting stage, and inputs for empty stages are ignored. `if_cause_i` and `mem_cause_i` use bit 0 = page fault, bit 1 = misaligned access, bit 2 = protection violation. `id_illegal_i` flags an undefined opcode and `ex_arith_i` an arithmetic fault.
- R4: `mem_we_o` is 1 only when the memory slot is occupied, `mem_we_req_i` is 1, the instruction's flags (including this cycle's `mem_cause_i`) are all clear, and no trap is taken that cycle.
- R5: `rf_we_o` is 0 whenever the writeback instruction carries any flag.
- R6: A trap (`trap_o` = 1) occurs only while an occupied writeback slot carries a flag or meets an interrupt. Traps are therefore taken in program order.
- R7: `trap_cause_o` uses 1 = fetch page fault, 2 = illegal opcode, 3 = arithmetic, 4 = data page fault, 5 = misaligned (fetch or data), 6 = protection (fetch or data), 7 = interrupt. With several flags, the earliest stage wins, and within a stage page fault beats misaligned, which beats protection.
- R8: On a fault trap, `trap_pc_o` is the PC of the faulting instruction. Older instructions have already completed with their writes intact.
- R9: During a trap cycle, `next_pc_o` equals `HANDLER_VEC`, and at the next clock every slot is empty, including the instruction fetched in the trap cycle.
- R10: In a trap cycle, the store of the younger instruction in the memory slot is suppressed.
- R11: With `irq_i` = 1 and an unflagged writeback instruction, that instruction's register write proceeds, `trap_cause_o` = 7 and `trap_pc_o` = its PC + `INSTR_BYTES`. With an empty writeback slot, `irq_i` has no effect. A flagged writeback instruction takes precedence over the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid_i | input | 1 | An instruction is in fetch this cycle |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| if_cause_i | input | 3 | Fetch causes: page fault, misaligned, protection |
| id_illegal_i | input | 1 | Decode found an undefined opcode |
| ex_arith_i | input | 1 | Execute raised an arithmetic fault |
| mem_cause_i | input | 3 | Memory-stage causes: page fault, misaligned, protection |
| mem_we_req_i | input | 1 | Memory-stage instruction wants to store |
| rf_we_req_i | input | 1 | Writeback instruction wants a register write |
| irq_i | input | 1 | External interrupt request (level) |
| trap_o | output | 1 | Trap taken this cycle; also the flush to the datapath |
| trap_cause_o | output | 3 | Cause code of the trap |
| trap_pc_o | output | PC_W | PC saved for the handler |
| next_pc_o | output | PC_W | Forced fetch address, valid with trap_o |
| mem_we_o | output | 1 | Gated data-memory write enable |
| rf_we_o | output | 1 | Gated register-file write enable |

## Verification
The properties assume that the stage cause inputs and write requests are steady for a whole cycle. They also assume that the surrounding pipeline accepts the flush and redirect in the trap cycle itself. The bench drives every stage input at the falling edge from a behavioural model of which instruction occupies which stage. When a stage is empty, the bench drives deliberately nonzero junk into it, so that R3 and R4 are exercised. It raises the interrupt at random, independently of the instruction stream. This covers interrupts against empty, clean and flagged writeback slots.

// File: rtl/exc_tracker_pkg.sv
package exc_tracker_pkg;

    // One flag per (stage, cause); bit index is also the reporting priority
    localparam int VEC_W      = 8;
    localparam int B_IF_PF    = 0;
    localparam int B_IF_MIS   = 1;
    localparam int B_IF_PROT  = 2;
    localparam int B_ID_ILL   = 3;
    localparam int B_EX_ARITH = 4;
    localparam int B_MEM_PF   = 5;
    localparam int B_MEM_MIS  = 6;
    localparam int B_MEM_PROT = 7;

    // Registered slots behind fetch: decode, execute, memory, writeback
    localparam int NSLOT = 4;
    localparam int S_ID  = 0;
    localparam int S_EX  = 1;
    localparam int S_MEM = 2;
    localparam int S_WB  = 3;

    typedef logic [VEC_W-1:0] exc_vec_t;
    typedef logic [2:0]       cause_t;

    localparam cause_t C_NONE  = 3'd0;
    localparam cause_t C_IPF   = 3'd1;
    localparam cause_t C_ILL   = 3'd2;
    localparam cause_t C_ARITH = 3'd3;
    localparam cause_t C_DPF   = 3'd4;
    localparam cause_t C_MIS   = 3'd5;
    localparam cause_t C_PROT  = 3'd6;
    localparam cause_t C_IRQ   = 3'd7;

    function automatic cause_t flag_to_cause(input int b);
        case (b)
            B_IF_PF:    return C_IPF;
            B_IF_MIS:   return C_MIS;
            B_IF_PROT:  return C_PROT;
            B_ID_ILL:   return C_ILL;
            B_EX_ARITH: return C_ARITH;
            B_MEM_PF:   return C_DPF;
            B_MEM_MIS:  return C_MIS;
            B_MEM_PROT: return C_PROT;
            default:    return C_NONE;
        endcase
    endfunction

endpackage

// File: rtl/exc_tracker_prio.sv
module exc_tracker_prio
    import exc_tracker_pkg::*;
(
    input  exc_vec_t vec_i,
    output cause_t   cause_o
);

    // Scan from the latest flag down so the earliest-stage flag is left last
    always_comb begin
        cause_o = C_NONE;
        for (int b = VEC_W - 1; b >= 0; b--) begin
            if (vec_i[b]) begin
                cause_o = flag_to_cause(b);
            end
        end
    end

endmodule

// File: rtl/exc_tracker_pipe.sv
module exc_tracker_pipe
    import exc_tracker_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_vld_i,
    input  logic [PC_W-1:0]                 in_pc_i,
    input  exc_vec_t                        in_raise_i,
    input  exc_vec_t [NSLOT-1:0]            raise_i,
    input  logic                            flush_i,
    output logic [NSLOT-1:0]                vld_o,
    output logic [NSLOT-1:0][PC_W-1:0]      pc_o,
    output exc_vec_t [NSLOT-1:0]            vec_o
);

    typedef struct packed {
        logic [NSLOT-1:0]           vld;
        exc_vec_t [NSLOT-1:0]       vec;
        logic [NSLOT-1:0][PC_W-1:0] pc;
    } pipe_t;

    pipe_t st_d, st_q;

    // Per-slot view: stored flags merged with what the stage reports now
    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            assign vld_o[g] = st_q.vld[g];
            assign pc_o[g]  = st_q.pc[g];
            assign vec_o[g] = st_q.vld[g] ? (st_q.vec[g] | raise_i[g]) : '0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.vld = '0;
            st_d.vec = '0;
        end else begin
            st_d.vld[0] = in_vld_i;
            st_d.vec[0] = in_vld_i ? in_raise_i : '0;
            st_d.pc[0]  = in_pc_i;
            for (int k = 1; k < NSLOT; k++) begin
                st_d.vld[k] = st_q.vld[k-1];
                st_d.vec[k] = vec_o[k-1];
                st_d.pc[k]  = st_q.pc[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/exc_tracker_wgate.sv
module exc_tracker_wgate
    import exc_tracker_pkg::*;
(
    input  logic     mem_vld_i,
    input  exc_vec_t mem_vec_i,
    input  logic     mem_req_i,
    input  logic     wb_vld_i,
    input  exc_vec_t wb_vec_i,
    input  logic     rf_req_i,
    input  logic     trap_i,
    output logic     mem_we_o,
    output logic     rf_we_o
);

    always_comb begin
        mem_we_o = mem_req_i && mem_vld_i && (mem_vec_i == '0) && !trap_i;
        rf_we_o  = rf_req_i && wb_vld_i && (wb_vec_i == '0);
    end

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
    import exc_tracker_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] HANDLER_VEC = 32'h0000_0180,
    parameter int              INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_valid_i,
    input  logic [PC_W-1:0] if_pc_i,
    input  logic [2:0]      if_cause_i,
    input  logic            id_illegal_i,
    input  logic            ex_arith_i,
    input  logic [2:0]      mem_cause_i,
    input  logic            mem_we_req_i,
    input  logic            rf_we_req_i,
    input  logic            irq_i,
    output logic            trap_o,
    output logic [2:0]      trap_cause_o,
    output logic [PC_W-1:0] trap_pc_o,
    output logic [PC_W-1:0] next_pc_o,
    output logic            mem_we_o,
    output logic            rf_we_o
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_BYTES);

    exc_vec_t                   if_raise;
    exc_vec_t [NSLOT-1:0]       stage_raise;
    logic [NSLOT-1:0]           slot_vld;
    logic [NSLOT-1:0][PC_W-1:0] slot_pc;
    exc_vec_t [NSLOT-1:0]       slot_vec;
    cause_t                     wb_cause;
    logic                       take_exc;
    logic                       take_irq;
    logic                       trap;

    // Place each stage's causes at its own flag positions
    always_comb begin
        if_raise                          = '0;
        if_raise[B_IF_PROT:B_IF_PF]       = if_cause_i;
        stage_raise                       = '0;
        stage_raise[S_ID][B_ID_ILL]       = id_illegal_i;
        stage_raise[S_EX][B_EX_ARITH]     = ex_arith_i;
        stage_raise[S_MEM][B_MEM_PROT:B_MEM_PF] = mem_cause_i;
    end

    exc_tracker_pipe #(
        .PC_W (PC_W)
    ) pipe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld_i   (if_valid_i),
        .in_pc_i    (if_pc_i),
        .in_raise_i (if_raise),
        .raise_i    (stage_raise),
        .flush_i    (trap),
        .vld_o      (slot_vld),
        .pc_o       (slot_pc),
        .vec_o      (slot_vec)
    );

    exc_tracker_prio prio_i (
        .vec_i   (slot_vec[S_WB]),
        .cause_o (wb_cause)
    );

    // Decision in writeback: a flagged instruction outranks an interrupt
    always_comb begin
        take_exc = slot_vld[S_WB] && (slot_vec[S_WB] != '0);
        take_irq = slot_vld[S_WB] && irq_i && !take_exc;
        trap     = take_exc || take_irq;

        trap_o       = trap;
        trap_cause_o = C_NONE;
        trap_pc_o    = '0;
        next_pc_o    = '0;
        if (take_exc) begin
            trap_cause_o = wb_cause;
            trap_pc_o    = slot_pc[S_WB];
        end else if (take_irq) begin
            trap_cause_o = C_IRQ;
            trap_pc_o    = slot_pc[S_WB] + PC_STEP;
        end
        if (trap) begin
            next_pc_o = HANDLER_VEC;
        end
    end

    exc_tracker_wgate wgate_i (
        .mem_vld_i (slot_vld[S_MEM]),
        .mem_vec_i (slot_vec[S_MEM]),
        .mem_req_i (mem_we_req_i),
        .wb_vld_i  (slot_vld[S_WB]),
        .wb_vec_i  (slot_vec[S_WB]),
        .rf_req_i  (rf_we_req_i),
        .trap_i    (trap),
        .mem_we_o  (mem_we_o),
        .rf_we_o   (rf_we_o)
    );

endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] HANDLER_VEC = 32'h0000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_o,
    input logic [2:0]      trap_cause_o,
    input logic [PC_W-1:0] next_pc_o,
    input logic            mem_we_o,
    input logic            rf_we_o,
    input logic [3:0]      slot_vld
);

    // R9: every slot empties after a trap
    a_r9_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (slot_vld == 4'b0000));

    // R9: fetch is redirected to the handler
    a_r9_handler_pc: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (next_pc_o == HANDLER_VEC));

    // R6: traps come only from an occupied writeback slot
    a_r6_trap_at_wb: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> slot_vld[3]);

    // R5: no register write on a fault trap
    a_r5_no_rf_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_cause_o != 3'd7) |-> !rf_we_o);

    // R10: no store from the younger instruction on a trap
    a_r10_no_mem_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !mem_we_o);

    // R2: an occupied decode slot moves into execute
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_o && slot_vld[0]) |=> slot_vld[1]);

    // R7: a trap always reports a real cause
    a_r7_cause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_cause_o != 3'd0));

    // R4: a store needs an occupied memory slot
    a_r4_mem_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> slot_vld[2]);

    // R2: a register write needs an occupied writeback slot
    a_r2_rf_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> slot_vld[3]);

endmodule

bind exc_tracker exc_tracker_chk #(
    .PC_W        (PC_W),
    .HANDLER_VEC (HANDLER_VEC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_o       (trap_o),
    .trap_cause_o (trap_cause_o),
    .next_pc_o    (next_pc_o),
    .mem_we_o     (mem_we_o),
    .rf_we_o      (rf_we_o),
    .slot_vld     (slot_vld)
);

// File: tb/exc_tracker_tb_top.sv
module exc_tracker_tb_top;

    localparam int PC_W   = 32;
    localparam int HVEC   = 32'h0000_0180;
    localparam int NI     = 2000;
    localparam int NCYC   = 2500;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            if_valid_i = 1'b0;
    logic [PC_W-1:0] if_pc_i = '0;
    logic [2:0]      if_cause_i = '0;
    logic            id_illegal_i = 1'b0;
    logic            ex_arith_i = 1'b0;
    logic [2:0]      mem_cause_i = '0;
    logic            mem_we_req_i = 1'b0;
    logic            rf_we_req_i = 1'b0;
    logic            irq_i = 1'b0;
    logic            trap_o;
    logic [2:0]      trap_cause_o;
    logic [PC_W-1:0] trap_pc_o;
    logic [PC_W-1:0] next_pc_o;
    logic            mem_we_o;
    logic            rf_we_o;

    always #2 clk = ~clk;

    exc_tracker #(.PC_W(PC_W), .HANDLER_VEC(HVEC), .INSTR_BYTES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .if_valid_i(if_valid_i), .if_pc_i(if_pc_i),
        .if_cause_i(if_cause_i), .id_illegal_i(id_illegal_i), .ex_arith_i(ex_arith_i),
        .mem_cause_i(mem_cause_i), .mem_we_req_i(mem_we_req_i), .rf_we_req_i(rf_we_req_i),
        .irq_i(irq_i), .trap_o(trap_o), .trap_cause_o(trap_cause_o), .trap_pc_o(trap_pc_o),
        .next_pc_o(next_pc_o), .mem_we_o(mem_we_o), .rf_we_o(rf_we_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Program table
    int pc_t [NI];
    int ifc_t [NI];
    int ill_t [NI];
    int ar_t [NI];
    int memc_t [NI];
    int mreq_t [NI];
    int rreq_t [NI];
    int vec_m [NI];
    int occ [4];
    int lcg = 32'h1234_5678;

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 1) & 32'h3fff_ffff;
    endfunction

    // Cause code from flag bits, per R7 and R3 positions
    function automatic int code_of(input int v);
        int tbl [8] = '{1, 5, 6, 2, 3, 4, 5, 6};
        for (int b = 0; b < 8; b++) begin
            if (v[b]) return tbl[b];
        end
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nxt;
        int cyc;
        for (int i = 0; i < NI; i++) begin
            int r;
            r = next_rand();
            pc_t[i]   = 32'h1000 + 4 * i;
            ifc_t[i]  = (r % 25 == 0) ? ((r >> 5) % 7) + 1 : 0;
            ill_t[i]  = ((r >> 9) % 30 == 0) ? 1 : 0;
            ar_t[i]   = ((r >> 14) % 30 == 0) ? 1 : 0;
            memc_t[i] = ((r >> 19) % 25 == 0) ? ((r >> 22) % 7) + 1 : 0;
            mreq_t[i] = (r >> 3) & 1;
            rreq_t[i] = (r >> 4) & 1;
            vec_m[i]  = 0;
        end
        // Directed: older MEM+EX fault vs younger fetch fault (order, priority)
        ifc_t[0] = 0; ill_t[0] = 0; ar_t[0] = 0; memc_t[0] = 0; rreq_t[0] = 1;
        ifc_t[1] = 0; ill_t[1] = 0; ar_t[1] = 1; memc_t[1] = 1; mreq_t[1] = 1;
        ifc_t[2] = 2; ill_t[2] = 0; ar_t[2] = 0; memc_t[2] = 0;
        ifc_t[3] = 5;
        for (int k = 0; k < 4; k++) occ[k] = -1;

        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 trap in reset", trap_o, 0);
        chk("R1 rf_we in reset", rf_we_o, 0);
        chk("R1 mem_we in reset", mem_we_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 trap idle", trap_o, 0);
        chk("R1 next_pc idle", next_pc_o, 0);
        chk("R1 trap_pc idle", trap_pc_o, 0);
        chk("R1 cause idle", trap_cause_o, 0);

        nxt = 0;
        for (cyc = 0; cyc < NCYC; cyc++) begin
            bit ifv;
            bit junk;
            int w, m, exc, irq, trap_e, cause_e, pc_e, rf_e, mem_e;
            @(negedge clk);
            junk = cyc[0];
            ifv = (nxt < NI) && ((cyc < 8) || (next_rand() % 5 != 0));
            if_valid_i  = ifv;
            if_pc_i     = ifv ? pc_t[nxt] : 32'hdead_0000;
            if_cause_i  = ifv ? 3'(ifc_t[nxt]) : {3{junk}};
            id_illegal_i = (occ[0] >= 0) ? ill_t[occ[0]][0] : junk;
            ex_arith_i   = (occ[1] >= 0) ? ar_t[occ[1]][0] : junk;
            mem_cause_i  = (occ[2] >= 0) ? 3'(memc_t[occ[2]]) : {3{junk}};
            mem_we_req_i = (occ[2] >= 0) ? mreq_t[occ[2]][0] : 1'b1;
            rf_we_req_i  = (occ[3] >= 0) ? rreq_t[occ[3]][0] : 1'b1;
            irq_i        = (cyc >= 8) && (next_rand() % 16 == 0);
            #1;
            w = occ[3];
            m = occ[2];
            exc = (w >= 0 && vec_m[w] != 0) ? 1 : 0;
            irq = (w >= 0 && irq_i && !exc) ? 1 : 0;
            trap_e  = exc | irq;
            cause_e = exc ? code_of(vec_m[w]) : (irq ? 7 : 0);
            pc_e    = exc ? pc_t[w] : (irq ? pc_t[w] + 4 : 0);
            rf_e    = (w >= 0 && rreq_t[w] != 0 && !exc) ? 1 : 0;
            mem_e   = (m >= 0 && mreq_t[m] != 0 &&
                       (vec_m[m] | (memc_t[m] << 5)) == 0 && !trap_e) ? 1 : 0;
            chk(exc ? "R6 trap on flagged WB" : (irq_i ? "R11 irq trap" : "R2 no trap"),
                trap_o, trap_e);
            chk(irq ? "R11 irq cause" : "R7 cause code", trap_cause_o, cause_e);
            chk(irq ? "R11 irq pc" : "R8 trap pc", trap_pc_o, pc_e);
            chk("R9 handler pc", next_pc_o, trap_e ? HVEC : 0);
            chk(exc ? "R5 rf gated" : (irq ? "R11 rf completes" : "R2 rf write"),
                rf_we_o, rf_e);
            chk((trap_e && m >= 0) ? "R10 mem on trap" :
                (m < 0 ? "R3 empty mem slot" : "R4 mem gate"), mem_we_o, mem_e);
            // advance model to the next edge
            if (trap_e) begin
                for (int k = 0; k < 4; k++) occ[k] = -1;
            end else begin
                if (occ[2] >= 0) vec_m[occ[2]] |= memc_t[occ[2]] << 5;
                if (occ[1] >= 0) vec_m[occ[1]] |= ar_t[occ[1]] << 4;
                if (occ[0] >= 0) vec_m[occ[0]] |= ill_t[occ[0]] << 3;
                occ[3] = occ[2];
                occ[2] = occ[1];
                occ[1] = occ[0];
                occ[0] = ifv ? nxt : -1;
                if (ifv) vec_m[nxt] = ifc_t[nxt];
            end
            if (ifv) nxt++;
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule